// File: doc/BRIEF.md
# Frame interrupt coalescing controller

This block decides when a video read channel raises its interrupt. Instead of interrupting on every frame, it collects events from three sources: a frame-count threshold, an inactivity delay timer and an error indication. Each source sets its own sticky status flag. A single level interrupt is raised while any flag whose enable bit is set is high. Software clears a flag by pulsing its write-one-to-clear input.

The threshold counter counts frame starts down from a programmed value and cannot be set to zero. The delay timer starts at the end of a frame and counts line events. In external-sync mode the end of a frame is marked by the frame-sync pulse. In free-run mode it is marked by the pulse that says all lines of a frame are complete. Any stream start-of-packet stops the timer, so the delay event fires only when the stream has gone quiet. Writing a new value to either field reloads its live counter at once.

Top module: `frm_irq_coalesce`

## Requirements
- R1: After reset the stored threshold is 1, the stored delay is 0, all enables are 0, all three status flags are 0 and `irq` is 0.
- R2: With threshold N, the frame-count flag (`sts_frm`) sets on the clock edge that samples the N-th `frame_start` pulse after the counter was loaded.
- R3: After the count reaches zero the counter reloads from the threshold, so the frame-count event repeats every N frame starts.
- R4: Writing a threshold of 0 stores 1, so every `frame_start` then sets the frame-count flag.
- R5: A write whose threshold differs from the stored one reloads the frame counter with the new value at once. A write of the same threshold leaves the count in progress unchanged.
- R6: When `ext_sync` is 1, the delay timer starts on `fsync`, and `frame_done` does not start it. Once started, the delay flag (`sts_dly`) sets on the D-th `line_tick`, where D is the stored delay. It sets once per start.
- R7: When `ext_sync` is 0, the delay timer starts on `frame_done`, and `fsync` does not start it.
- R8: A `sop` pulse stops a running delay timer. No delay event follows until the next start pulse, after which a full D line ticks are needed.
- R9: A stored delay of 0 disables the delay event completely.
- R10: A write whose delay differs from the stored one discards the ticks counted so far. The timer keeps running if the new delay is nonzero and then needs the full new delay.
- R11: `err_in` high at a clock edge sets the error flag (`sts_err`).
- R12: Pulsing `clr_frm`, `clr_dly` or `clr_err` clears its flag at the next edge. When a set and a clear fall in the same cycle, the set wins.
- R13: Each flag sets whether or not it is enabled. `irq` is high exactly while some flag is set and its enable (`cfg_en_frm`, `cfg_en_dly`, `cfg_en_err`, stored on `cfg_we`) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for threshold, delay and enables |
| cfg_thresh | input | 8 | Frame threshold (0 stores 1) |
| cfg_delay | input | 8 | Delay in line ticks (0 disables) |
| cfg_en_frm | input | 1 | Frame-count interrupt enable |
| cfg_en_dly | input | 1 | Delay interrupt enable |
| cfg_en_err | input | 1 | Error interrupt enable |
| ext_sync | input | 1 | 1 = timer starts on fsync, 0 = on frame_done |
| frame_start | input | 1 | Frame start pulse |
| fsync | input | 1 | External frame-sync pulse |
| frame_done | input | 1 | All lines of a frame completed pulse |
| line_tick | input | 1 | Line event pulse counted by the delay timer |
| sop | input | 1 | Stream start-of-packet strobe |
| err_in | input | 1 | Error indication |
| clr_frm | input | 1 | Write-one-to-clear for frame-count flag |
| clr_dly | input | 1 | Write-one-to-clear for delay flag |
| clr_err | input | 1 | Write-one-to-clear for error flag |
| sts_frm | output | 1 | Sticky frame-count flag |
| sts_dly | output | 1 | Sticky delay flag |
| sts_err | output | 1 | Sticky error flag |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume that all inputs are synchronous to `clk`, that event inputs are plain pulses, and that a configuration write, an event and a clear may all land in the same cycle. The priority rules (reload over frame tick, start-of-packet over everything in the timer, set over clear) are what the properties lean on. The stimulus changes every input half a cycle away from the active edge and holds each pulse for exactly one cycle. It rewrites the configuration only with values chosen to either hit or avoid a reload, so every count window the bench expects is exact.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;
   localparam int NSRC = 3;
   typedef enum logic [1:0] {
      SRC_FRM = 2'd0,
      SRC_DLY = 2'd1,
      SRC_ERR = 2'd2
   } irq_src_e;
endpackage

// File: rtl/frm_thresh_ctr.sv
module frm_thresh_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   input  logic         tick,
   output logic         evt
);
   localparam logic [W-1:0] ONE = W'(1);

   if (W < 2) begin : g_bad_w
      $error("frm_thresh_ctr: W must be at least 2");
   end

   logic [W-1:0] thr_q, cnt_q, new_thr;
   logic         reload;

   // a zero threshold is promoted to the minimum of one
   assign new_thr = (wr_val == '0) ? ONE : wr_val;
   assign reload  = wr && (new_thr != thr_q);
   assign evt     = tick && !reload && (cnt_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q <= ONE;
         cnt_q <= ONE;
      end else if (reload) begin
         thr_q <= new_thr;
         cnt_q <= new_thr;
      end else if (tick) begin
         cnt_q <= (cnt_q == ONE) ? thr_q : cnt_q - ONE;
      end
   end

   p_thr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      thr_q != '0);
   p_cnt_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);
   p_reload_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q == $past(new_thr)));
endmodule

// File: rtl/frm_delay_tmr.sv
module frm_delay_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wr_val,
   input  logic         ext_sync,
   input  logic         fsync,
   input  logic         frame_done,
   input  logic         line_tick,
   input  logic         sop,
   output logic         evt
);
   if (W < 2) begin : g_bad_w
      $error("frm_delay_tmr: W must be at least 2");
   end

   logic [W-1:0] dly_q, cnt_q, cnt_nx;
   logic         armed_q, reload, trig, last;

   assign reload = wr && (wr_val != dly_q);
   assign trig   = ext_sync ? fsync : frame_done;
   assign cnt_nx = cnt_q + W'(1);
   assign last   = (cnt_nx == dly_q);
   assign evt    = armed_q && line_tick && last && !sop && !reload && !trig;

   always_ff @(posedge clk) begin
      if (!rst_n)      dly_q <= '0;
      else if (reload) dly_q <= wr_val;
   end

   // priority: packet activity, then reload, then start, then counting
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (sop) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (reload) begin
         armed_q <= armed_q && (wr_val != '0);
         cnt_q   <= '0;
      end else if (trig) begin
         armed_q <= (dly_q != '0);
         cnt_q   <= '0;
      end else if (armed_q && line_tick) begin
         if (last) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            cnt_q   <= cnt_nx;
         end
      end
   end

   p_cnt_below_dly_r6: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (cnt_q < dly_q));
   p_sop_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sop |=> !armed_q);
   p_zero_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dly_q == '0) |-> !armed_q);
endmodule

// File: rtl/frm_irq_status.sv
module frm_irq_status #(
   parameter int N = frm_irq_pkg::NSRC
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] sts,
   output logic         irq
);
   if (N < 1) begin : g_bad_n
      $error("frm_irq_status: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      sts[i] <= 1'b0;
         else if (set[i]) sts[i] <= 1'b1;
         else if (clr[i]) sts[i] <= 1'b0;
      end

      p_set_sticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> sts[i]);
      p_clr_works_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !sts[i]);
   end

   assign irq = |(sts & en);
endmodule

// File: rtl/frm_irq_coalesce.sv
module frm_irq_coalesce #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_thresh,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic             cfg_en_frm,
   input  logic             cfg_en_dly,
   input  logic             cfg_en_err,
   input  logic             ext_sync,
   input  logic             frame_start,
   input  logic             fsync,
   input  logic             frame_done,
   input  logic             line_tick,
   input  logic             sop,
   input  logic             err_in,
   input  logic             clr_frm,
   input  logic             clr_dly,
   input  logic             clr_err,
   output logic             sts_frm,
   output logic             sts_dly,
   output logic             sts_err,
   output logic             irq
);
   import frm_irq_pkg::*;

   logic [NSRC-1:0] en_q, set_v, clr_v, sts_v;
   logic            frm_evt, dly_evt;

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= '0;
      else if (cfg_we) begin
         en_q[SRC_FRM] <= cfg_en_frm;
         en_q[SRC_DLY] <= cfg_en_dly;
         en_q[SRC_ERR] <= cfg_en_err;
      end
   end

   frm_thresh_ctr #(.W(CNT_W)) u_thr (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .wr_val(cfg_thresh),
      .tick(frame_start), .evt(frm_evt)
   );

   frm_delay_tmr #(.W(CNT_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .wr(cfg_we), .wr_val(cfg_delay),
      .ext_sync(ext_sync), .fsync(fsync), .frame_done(frame_done),
      .line_tick(line_tick), .sop(sop), .evt(dly_evt)
   );

   always_comb begin
      set_v          = '0;
      clr_v          = '0;
      set_v[SRC_FRM] = frm_evt;
      set_v[SRC_DLY] = dly_evt;
      set_v[SRC_ERR] = err_in;
      clr_v[SRC_FRM] = clr_frm;
      clr_v[SRC_DLY] = clr_dly;
      clr_v[SRC_ERR] = clr_err;
   end

   frm_irq_status #(.N(NSRC)) u_sts (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .en(en_q),
      .sts(sts_v), .irq(irq)
   );

   assign sts_frm = sts_v[SRC_FRM];
   assign sts_dly = sts_v[SRC_DLY];
   assign sts_err = sts_v[SRC_ERR];

   p_masked_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
   p_err_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_in |=> sts_err);
endmodule

// File: tb/frm_irq_coalesce_tb.sv
module frm_irq_coalesce_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_en_frm = 0, cfg_en_dly = 0, cfg_en_err = 0;
   logic [7:0] cfg_thresh = 0, cfg_delay = 0;
   logic ext_sync = 0, frame_start = 0, fsync = 0, frame_done = 0;
   logic line_tick = 0, sop = 0, err_in = 0;
   logic clr_frm = 0, clr_dly = 0, clr_err = 0;
   logic sts_frm, sts_dly, sts_err, irq;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   frm_irq_coalesce dut_i (.*);

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [7:0] t, input logic [7:0] d,
                      input logic ef, input logic ed, input logic ee);
      cfg_thresh = t; cfg_delay = d;
      cfg_en_frm = ef; cfg_en_dly = ed; cfg_en_err = ee;
      cfg_we = 1; @(negedge clk); cfg_we = 0;
   endtask

   // 0 frame_start, 1 fsync, 2 frame_done, 3 line_tick, 4 sop
   task automatic pulse(input int which, input int n);
      for (int k = 0; k < n; k++) begin
         case (which)
            0: frame_start = 1;
            1: fsync = 1;
            2: frame_done = 1;
            3: line_tick = 1;
            default: sop = 1;
         endcase
         @(negedge clk);
         frame_start = 0; fsync = 0; frame_done = 0; line_tick = 0; sop = 0;
      end
   endtask

   task automatic clear_all();
      clr_frm = 1; clr_dly = 1; clr_err = 1;
      @(negedge clk);
      clr_frm = 0; clr_dly = 0; clr_err = 0;
   endtask

   task automatic t_reset();
      check("R1 sts_frm", sts_frm, 0);
      check("R1 sts_dly", sts_dly, 0);
      check("R1 sts_err", sts_err, 0);
      check("R1 irq", irq, 0);
      pulse(0, 1);   // threshold 1 after reset
      check("R1 threshold one", sts_frm, 1);
      check("R1 enables off", irq, 0);
      clear_all();
   endtask

   task automatic t_frame_count();
      cfg(8'd3, 8'd0, 1, 0, 0);
      pulse(0, 2);
      check("R2 before threshold", sts_frm, 0);
      pulse(0, 1);
      check("R2 at threshold", sts_frm, 1);
      check("R13 irq frm", irq, 1);
      clear_all();
      check("R12 cleared", sts_frm, 0);
      pulse(0, 2);
      check("R3 reload wait", sts_frm, 0);
      pulse(0, 1);
      check("R3 repeat", sts_frm, 1);
      clear_all();
   endtask

   task automatic t_zero_thr();
      cfg(8'd0, 8'd0, 1, 0, 0);
      pulse(0, 1);
      check("R4 first", sts_frm, 1);
      clear_all();
      pulse(0, 1);
      check("R4 second", sts_frm, 1);
      clear_all();
   endtask

   task automatic t_reload();
      cfg(8'd4, 8'd0, 1, 0, 0);
      pulse(0, 2);
      cfg(8'd2, 8'd0, 1, 0, 0);
      pulse(0, 1);
      check("R5 reload no early", sts_frm, 0);
      pulse(0, 1);
      check("R5 reload hit", sts_frm, 1);
      clear_all();
      pulse(0, 1);
      cfg(8'd2, 8'd0, 1, 0, 0);
      pulse(0, 1);
      check("R5 same value keeps count", sts_frm, 1);
      clear_all();
   endtask

   task automatic t_ext();
      ext_sync = 1;
      cfg(8'd2, 8'd3, 0, 1, 0);
      pulse(2, 1);
      pulse(3, 3);
      check("R6 frame_done ignored", sts_dly, 0);
      pulse(1, 1);
      pulse(3, 2);
      check("R6 before delay", sts_dly, 0);
      pulse(3, 1);
      check("R6 at delay", sts_dly, 1);
      check("R13 irq dly", irq, 1);
      clear_all();
      pulse(3, 4);
      check("R6 fires once", sts_dly, 0);
   endtask

   task automatic t_free();
      ext_sync = 0;
      pulse(1, 1);
      pulse(3, 3);
      check("R7 fsync ignored", sts_dly, 0);
      pulse(2, 1);
      pulse(3, 3);
      check("R7 fires", sts_dly, 1);
      clear_all();
   endtask

   task automatic t_sop();
      pulse(2, 1);
      pulse(3, 2);
      pulse(4, 1);
      pulse(3, 3);
      check("R8 sop cancels", sts_dly, 0);
      pulse(2, 1);
      pulse(3, 2);
      check("R8 restart partial", sts_dly, 0);
      pulse(3, 1);
      check("R8 restart full", sts_dly, 1);
      clear_all();
   endtask

   task automatic t_dly_zero();
      cfg(8'd2, 8'd0, 0, 1, 0);
      pulse(2, 1);
      pulse(3, 5);
      check("R9 zero disables", sts_dly, 0);
   endtask

   task automatic t_dly_rewrite();
      cfg(8'd2, 8'd3, 0, 1, 0);
      pulse(2, 1);
      pulse(3, 2);
      cfg(8'd2, 8'd4, 0, 1, 0);
      pulse(3, 3);
      check("R10 progress dropped", sts_dly, 0);
      pulse(3, 1);
      check("R10 new delay", sts_dly, 1);
      clear_all();
   endtask

   task automatic t_err();
      cfg(8'd2, 8'd4, 0, 0, 1);
      err_in = 1; @(negedge clk); err_in = 0;
      check("R11 err set", sts_err, 1);
      check("R13 irq err", irq, 1);
      err_in = 1; clr_err = 1; @(negedge clk);
      err_in = 0; clr_err = 0;
      check("R12 set wins", sts_err, 1);
      clr_err = 1; @(negedge clk); clr_err = 0;
      check("R12 clear", sts_err, 0);
      check("R13 irq low", irq, 0);
   endtask

   task automatic t_mask();
      cfg(8'd2, 8'd4, 0, 0, 0);
      err_in = 1; @(negedge clk); err_in = 0;
      pulse(0, 2);
      check("R13 frm sets masked", sts_frm, 1);
      check("R13 err sets masked", sts_err, 1);
      check("R13 masked irq", irq, 0);
      cfg(8'd2, 8'd4, 1, 0, 0);
      check("R13 enable raises irq", irq, 1);
      clr_frm = 1; @(negedge clk); clr_frm = 0;
      check("R13 err still masked", irq, 0);
      clear_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_frame_count();
      t_zero_thr();
      t_reload();
      t_ext();
      t_free();
      t_sop();
      t_dly_zero();
      t_dly_rewrite();
      t_err();
      t_mask();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule